// File: doc/BRIEF.md
# Training-Based Bit Period Detector

This block measures the bit period of an asynchronous serial line in units of a fast local oversampling clock. Once software or a link controller pulses a start-training strobe, the block times the gaps between successive transitions on the line. It does this while the far end sends a preamble that is dense in edges. The shortest gap that several measurements agree on is taken as one bit time. That value is published, together with its half, and a lock flag. A downstream clock generator uses the period as its bit timer and the half period as the reload for its mid-bit sampling timer.

The line is passed through a two-flop synchronizer before edge detection. A gap of one tick is treated as a glitch. A gap longer than the configured maximum is treated as an idle line, and the search starts over. A gap much longer than the current estimate is treated as a run of identical bits and is skipped. Bits seen during training are used only for measurement and never leave the block as data. After lock, the published value stays frozen until the next training request.

The controller has four states. ST_IDLE is entered from reset and leaves on the strobe. ST_ARM waits for a first edge. ST_MEASURE collects gaps. ST_LOCKED holds the result. The strobe moves any state to ST_ARM. An edge moves ST_ARM to ST_MEASURE. A timeout moves ST_MEASURE back to ST_ARM. The final agreeing gap moves ST_MEASURE to ST_LOCKED.

Top module: `bit_period_detector`

## Requirements
- R1: After reset, `locked`, `period` and `half_period` are 0. Transitions on `rx_line` before the first `train_start` pulse cause no lock.
- R2: A measured gap is the number of clock cycles between two successive changes of `rx_line`. After a training pulse, N_AGREE (default 4) agreeing gaps raise `locked`, and `period` then equals that gap in ticks.
- R3: A gap agrees when it lies within ±1 tick of the current estimate. The estimate becomes the smaller of the two, so alternating gaps of 10 and 9 lock at 9.
- R4: A gap more than one tick longer than the estimate is skipped and does not count toward agreement. This covers runs of identical bits. Gaps of 7,14,7,21,7,7 lock at 7.
- R5: A gap shorter than 2 ticks is rejected as a glitch, and timing restarts from the glitch edge. Gaps of 12,1,12,12,12 lock at 12.
- R6: If no edge arrives within MAX_PERIOD (default 64) ticks, the agreement count is discarded and the next edge starts a fresh measurement. Gaps of 6,6,100,20,20,20,20 lock at 20.
- R7: `half_period` equals `period` shifted right by one, rounding down for odd values.
- R8: While locked and with no new training pulse, `locked` stays 1 and `period` does not change, whatever happens on `rx_line`.
- R9: A `train_start` pulse drops `locked` on the next cycle. `period` keeps its old value until a new lock.
- R10: A gap more than one tick shorter than the estimate replaces it and restarts the agreement count at 1. Gaps of 10,10,10,5,5,5,5 lock at 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial line |
| train_start | input | 1 | One-cycle pulse that begins a new training search |
| period | output | CW | Locked bit period in ticks, CW = clog2(MAX_PERIOD+1) |
| half_period | output | CW | Locked period shifted right by one |
| locked | output | 1 | Period value is valid and frozen |

## Verification
A corrupted estimate or agreement count shows at the ports in one of two ways. Either `locked` rises with a wrong `period`, or it never rises within a few edges after the preamble ends. The bench therefore compares each lock event against a queued expectation and treats a missing lock as a failure. A controller stuck in the wrong state shows within one cycle: `locked` fails to drop after a training pulse, or `period` moves while locked.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_MEASURE,
        ST_LOCKED
    } bpd_state_e;
endpackage

// File: rtl/bpd_sync_edge.sv
module bpd_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o
);
    logic [SYNC_STAGES:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], line_i};
    end

    // Newest synchronized sample against the one before it
    assign edge_o = pipe_q[SYNC_STAGES-1] ^ pipe_q[SYNC_STAGES];
endmodule

// File: rtl/bpd_gap_timer.sv
module bpd_gap_timer #(
    parameter  int MAX_PERIOD = 64,
    localparam int CW = $clog2(MAX_PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          edge_i,
    output logic [CW-1:0] gap_o,
    output logic          timeout_o
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (edge_i)         cnt_q <= CW'(1);
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + CW'(1);
    end

    assign gap_o     = cnt_q;
    assign timeout_o = !edge_i && (cnt_q == LIMIT);
endmodule

// File: rtl/bpd_lock_fsm.sv
module bpd_lock_fsm
    import bpd_pkg::*;
#(
    parameter  int MAX_PERIOD = 64,
    parameter  int N_AGREE    = 4,
    parameter  int MIN_GAP    = 2,
    localparam int CW = $clog2(MAX_PERIOD + 1),
    localparam int AW = $clog2(N_AGREE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          train_start_i,
    input  logic          edge_i,
    input  logic          timeout_i,
    input  logic [CW-1:0] gap_i,
    output logic [CW-1:0] period_o,
    output logic          locked_o
);
    bpd_state_e    state_q, state_d;
    logic [CW-1:0] best_q, best_d, period_q, period_d;
    logic [AW-1:0] agree_q, agree_d;
    logic          gap_ok, close, shorter;

    assign gap_ok  = edge_i && (gap_i >= CW'(MIN_GAP));
    assign close   = ({1'b0, gap_i} <= {1'b0, best_q} + 1'b1) &&
                     ({1'b0, gap_i} + 1'b1 >= {1'b0, best_q});
    assign shorter = ({1'b0, gap_i} + 1'b1 < {1'b0, best_q});

    always_comb begin
        state_d  = state_q;
        best_d   = best_q;
        agree_d  = agree_q;
        period_d = period_q;
        if (train_start_i) begin
            state_d = ST_ARM;
            agree_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE:   ;
                ST_ARM: if (edge_i) begin
                    state_d = ST_MEASURE;
                    agree_d = '0;
                end
                ST_MEASURE: begin
                    if (timeout_i) begin
                        state_d = ST_ARM;
                        agree_d = '0;
                    end else if (gap_ok) begin
                        if (agree_q == '0 || shorter) begin
                            best_d  = gap_i;
                            agree_d = AW'(1);
                        end else if (close) begin
                            best_d  = (gap_i < best_q) ? gap_i : best_q;
                            agree_d = agree_q + AW'(1);
                        end
                        if (agree_d == AW'(N_AGREE)) begin
                            state_d  = ST_LOCKED;
                            period_d = best_d;
                        end
                    end
                end
                ST_LOCKED: ;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_q   <= '0;
            agree_q  <= '0;
            period_q <= '0;
        end else begin
            best_q   <= best_d;
            agree_q  <= agree_d;
            period_q <= period_d;
        end
    end

    always_comb begin
        period_o = period_q;
        locked_o = (state_q == ST_LOCKED);
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !locked_o && (period_o == '0)); // R1
    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (period_o >= CW'(MIN_GAP)) && (period_o <= CW'(MAX_PERIOD))); // R2
    AST_TIMEOUT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MEASURE && timeout_i && !train_start_i) |=> (state_q == ST_ARM)); // R6
    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !train_start_i) |=> locked_o && $stable(period_o)); // R8
    AST_START_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        train_start_i |=> !locked_o && $stable(period_o)); // R9
endmodule

// File: rtl/bit_period_detector.sv
module bit_period_detector #(
    parameter  int MAX_PERIOD  = 64,
    parameter  int N_AGREE     = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int CW = $clog2(MAX_PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          train_start,
    output logic [CW-1:0] period,
    output logic [CW-1:0] half_period,
    output logic          locked
);
    logic          line_edge;
    logic          gap_timeout;
    logic [CW-1:0] gap_ticks;

    bpd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (rx_line),
        .edge_o (line_edge)
    );

    bpd_gap_timer #(.MAX_PERIOD(MAX_PERIOD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (line_edge),
        .gap_o     (gap_ticks),
        .timeout_o (gap_timeout)
    );

    bpd_lock_fsm #(.MAX_PERIOD(MAX_PERIOD), .N_AGREE(N_AGREE)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .train_start_i (train_start),
        .edge_i        (line_edge),
        .timeout_i     (gap_timeout),
        .gap_i         (gap_ticks),
        .period_o      (period),
        .locked_o      (locked)
    );

    // R7: mid-bit reload, odd periods round down
    assign half_period = period >> 1;
endmodule

// File: tb/bit_period_detector_tb.sv
`timescale 1ns/1ps
module bit_period_detector_tb;
    localparam int CW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_line = 1'b0;
    logic          train_start = 1'b0;
    logic [CW-1:0] period, half_period;
    logic          locked;

    int total = 0;
    int bad = 0;
    int gq[$];
    int exp_q[$];
    string tag_q[$];
    logic lk_d = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    bit_period_detector u_dut (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .train_start(train_start),
        .period(period), .half_period(half_period), .locked(locked)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: pops an expectation on every rising lock
    always @(negedge clk) begin
        if (rst_n && locked && !lk_d) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected lock", int'(period), -1);
            end else begin
                automatic int e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(period == CW'(e), {t, " period"}, int'(period), e);
                chk(half_period == CW'(e / 2), {t, " half_period R7"}, int'(half_period), e / 2);
            end
        end
        lk_d = locked;
    end

    task automatic send_gaps();
        rx_line = ~rx_line;
        foreach (gq[i]) begin
            repeat (gq[i]) @(negedge clk);
            rx_line = ~rx_line;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) train_start = 1'b1;
        @(negedge clk) train_start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic train(input int expv, input string tag);
        pulse_start();
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        send_gaps();
        for (int w = 0; w < 400 && exp_q.size() != 0; w++) @(negedge clk);
        if (exp_q.size() != 0) begin
            chk(1'b0, {tag, " no lock"}, 0, expv);
            exp_q.delete();
            tag_q.delete();
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(locked == 1'b0, "R1 reset locked", int'(locked), 0);
        chk(period == '0, "R1 reset period", int'(period), 0);
        chk(half_period == '0, "R1 reset half", int'(half_period), 0);
        gq = '{8, 8, 8, 8, 8, 8};
        send_gaps();
        repeat (8) @(negedge clk);
        chk(locked == 1'b0, "R1 no lock before training", int'(locked), 0);

        gq = '{10, 10, 10, 10};
        train(10, "R2 steady 10");

        gq = '{30, 30, 3, 3, 3, 3};
        send_gaps();
        repeat (8) @(negedge clk);
        chk(locked == 1'b1, "R8 lock held", int'(locked), 1);
        chk(period == CW'(10), "R8 period frozen", int'(period), 10);

        @(negedge clk) train_start = 1'b1;
        @(negedge clk) train_start = 1'b0;
        chk(locked == 1'b0, "R9 lock dropped", int'(locked), 0);
        chk(period == CW'(10), "R9 period kept", int'(period), 10);
        repeat (4) @(negedge clk);

        gq = '{10, 9, 10, 9};
        train(9, "R3 alternating");

        gq = '{7, 14, 7, 21, 7, 7};
        train(7, "R4 runs skipped");

        gq = '{12, 1, 12, 12, 12};
        train(12, "R5 glitch rejected");

        gq = '{6, 6, 100, 20, 20, 20, 20};
        train(20, "R6 idle restart");

        gq = '{10, 10, 10, 5, 5, 5, 5};
        train(5, "R10 shorter replaces");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule